// File: doc/BRIEF.md
# Parallel NOR Flash Command Decoder

This block is a behavioural model of the command interface of a parallel NOR flash memory with a small built-in array. A write cycle counts when chip select and write enable are both low and the low-supply flag is clear. The decoder reads the address and data of each write cycle and follows multi-write unlock and command sequences. A sequence that completes starts a byte program or a sector erase in an internal operation engine. The engine holds the target address and data, stays busy for a fixed number of cycles, and then updates the array.

The decoder is a single state machine with these states:
- `ST_READ`: idle, array read.
- `ST_U1` and `ST_U2`: first and second unlock write seen.
- `ST_PGM`: waiting for the program address/data write.
- `ST_ES`: erase setup seen.
- `ST_EU1` and `ST_EU2`: the two erase unlock writes.
- `ST_BYP`: bypass idle.
- `ST_BPGM`: bypass program, waiting for address/data.
- `ST_BEXIT`: first bypass exit write seen.

Transitions:
- `ST_READ`→`ST_U1`→`ST_U2` on the unlock pair.
- From `ST_U2`: →`ST_PGM`, →`ST_ES` or →`ST_BYP`.
- `ST_PGM`→`ST_READ`, which also launches the program.
- `ST_ES`→`ST_EU1`→`ST_EU2`→`ST_READ`, which also launches the erase.
- `ST_BYP`→`ST_BPGM`→`ST_BYP`, which also launches the program.
- `ST_BYP`→`ST_BEXIT`→`ST_READ` (leave bypass) or →`ST_BYP` (stay).
- Any unexpected write returns to the base state.

The operation engine keeps a separate erase context. An erase can therefore be suspended, a program can run in another sector while it is suspended, and the erase can then be resumed. Reads return array data when the engine is idle and a status byte while it is busy. An active-low hardware reset aborts everything and returns the model to its power-on state: read mode with an erased array.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: Normal program takes four writes: 0xAA to word address 0x555, 0x55 to 0x2AA, 0xA0 to 0x555, then the address/data. `busy` is then high for exactly PGM_CYC cycles, after which the byte reads back programmed.
- R2: The sequence AA/555, 55/2AA, 20/555 enters bypass. In bypass, a program takes two writes: 0xA0 to any address, then the address/data. Writing 0x90 and then 0x00 leaves bypass, after which a two-write program is ignored.
- R3: A write that does not fit the expected step of a sequence returns the decoder to its base state and starts no operation. A correct sequence issued afterwards works.
- R4: Low `rst_n` aborts any operation at once (`busy` low), leaves bypass and erase suspend, returns to read mode, and reinitialises the array to all 0xFF.
- R5: A program or erase that targets a sector whose `prot` bit is 1 is rejected: `busy` stays low and the data is unchanged. The sector number is the top two bits of the 6-bit array index.
- R6: While `pwr_low` is 1, no write cycle is accepted.
- R7: 0xB0 written during an erase suspends it, and `busy` is low from the next cycle. While the erase is suspended, the array is readable, a program to another sector runs normally, and a program to the suspended sector is rejected. 0x30 written in the base state resumes the erase, which then completes.
- R8: Writes that arrive while `busy` is high are ignored, apart from the suspend command during an erase.
- R9: Sector erase takes six writes: AA/555, 55/2AA, 80/555, AA/555, 55/2AA, then 0x30 to any address in the sector. `busy` is then high for ERS_CYC cycles, after which every byte of that sector reads 0xFF and other sectors are unchanged.
- R10: While `busy` is high, a read returns a status byte. Bit 7 is the complement of bit 7 of the data being programmed, or 0 during an erase. Bit 6 flips on every clock with a read strobe (CS and OE low). Bits 5..0 are zero.
- R11: Programming can only clear bits: the new content is the old content ANDed with the written data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, asynchronous |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| pwr_low | input | 1 | Low-supply flag; blocks writes when 1 |
| addr | input | ADDR_W (11) | Bus word address |
| wdata | input | 8 | Write data |
| prot | input | SECTORS (4) | Per-sector protection, 1 = protected |
| rdata | output | 8 | Array data or status byte |
| busy | output | 1 | High while an operation is running |

## Verification
A decoder left in the wrong sequence state shows up on the next write that should start an operation. Either `busy` fails to rise on the cycle after the final write, or it rises where it should not, so the error is visible one cycle after the offending write. A wrong erase context, such as a suspend that is not taken or a resume into the wrong sector, shows in `busy` on the cycle after the suspend or resume write, and in the array contents once the operation ends. A bad status path is caught on the first busy read, through bit 7 and through bit 6 failing to change between two consecutive strobed cycles.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
    typedef enum logic [3:0] {
        ST_READ, ST_U1, ST_U2, ST_PGM, ST_ES, ST_EU1, ST_EU2,
        ST_BYP, ST_BPGM, ST_BEXIT
    } seq_state_t;

    localparam logic [7:0]  CMD_KEY1      = 8'hAA;
    localparam logic [7:0]  CMD_KEY2      = 8'h55;
    localparam logic [7:0]  CMD_PROGRAM   = 8'hA0;
    localparam logic [7:0]  CMD_ERS_SETUP = 8'h80;
    localparam logic [7:0]  CMD_ERS_SECT  = 8'h30;
    localparam logic [7:0]  CMD_SUSPEND   = 8'hB0;
    localparam logic [7:0]  CMD_RESUME    = 8'h30;
    localparam logic [7:0]  CMD_BYP_ENTER = 8'h20;
    localparam logic [7:0]  CMD_BYP_LEAVE = 8'h90;
    localparam logic [7:0]  CMD_BYP_DONE  = 8'h00;
    localparam int          KEY_AW        = 11;
    localparam logic [10:0] KEY_ADR1      = 11'h555;
    localparam logic [10:0] KEY_ADR2      = 11'h2AA;
endpackage

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    output logic              start_pgm,
    output logic              start_ers,
    output logic              sus_req,
    output logic              rsm_req
);
    seq_state_t state, nxt;
    logic go, key1_hit, key2_hit, at_cmd_adr;

    assign go         = wr && !busy;
    assign at_cmd_adr = (addr[KEY_AW-1:0] == KEY_ADR1);
    assign key1_hit   = at_cmd_adr && (data == CMD_KEY1);
    assign key2_hit   = (addr[KEY_AW-1:0] == KEY_ADR2) && (data == CMD_KEY2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_READ;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (go) begin
            unique case (state)
                ST_READ:  nxt = key1_hit ? ST_U1 : ST_READ;
                ST_U1:    nxt = key2_hit ? ST_U2 : ST_READ;
                ST_U2: begin
                    if (at_cmd_adr && data == CMD_PROGRAM)        nxt = ST_PGM;
                    else if (at_cmd_adr && data == CMD_ERS_SETUP) nxt = ST_ES;
                    else if (at_cmd_adr && data == CMD_BYP_ENTER) nxt = ST_BYP;
                    else                                          nxt = ST_READ;
                end
                ST_PGM:   nxt = ST_READ;
                ST_ES:    nxt = key1_hit ? ST_EU1 : ST_READ;
                ST_EU1:   nxt = key2_hit ? ST_EU2 : ST_READ;
                ST_EU2:   nxt = ST_READ;
                ST_BYP: begin
                    if (data == CMD_PROGRAM)        nxt = ST_BPGM;
                    else if (data == CMD_BYP_LEAVE) nxt = ST_BEXIT;
                    else                            nxt = ST_BYP;
                end
                ST_BPGM:  nxt = ST_BYP;
                ST_BEXIT: nxt = (data == CMD_BYP_DONE) ? ST_READ : ST_BYP;
                default:  nxt = ST_READ;
            endcase
        end
    end

    always_comb begin
        start_pgm = go && (state == ST_PGM || state == ST_BPGM);
        start_ers = go && (state == ST_EU2) && (data == CMD_ERS_SECT);
        rsm_req   = go && (state == ST_READ || state == ST_BYP) && (data == CMD_RESUME);
        sus_req   = wr && busy && (data == CMD_SUSPEND);
    end

    // R1: the command step is only reached through the unlock pair
    p_key_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_U2 |-> ($past(state) == ST_U1 || $past(state) == ST_U2));

    // R2: the two-write program is only reachable from bypass idle
    p_bypass_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_BPGM |-> ($past(state) == ST_BYP || $past(state) == ST_BPGM));
endmodule

// File: rtl/nor_cell_array.sv
module nor_cell_array #(
    parameter int ARR_AW = 6,
    parameter int SEC_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pgm_en,
    input  logic [ARR_AW-1:0] pgm_idx,
    input  logic [7:0]        pgm_data,
    input  logic              ers_en,
    input  logic [SEC_W-1:0]  ers_sec,
    input  logic [ARR_AW-1:0] rd_idx,
    output logic [7:0]        rd_data
);
    localparam int DEPTH = 1 << ARR_AW;
    localparam int SHIFT = ARR_AW - SEC_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (ers_en && SEC_W'(i >> SHIFT) == ers_sec) mem[i] <= 8'hFF;
                else if (pgm_en && ARR_AW'(i) == pgm_idx) mem[i] <= mem[i] & pgm_data;
            end
        end
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/nor_op_engine.sv
module nor_op_engine #(
    parameter int ARR_AW  = 6,
    parameter int SECTORS = 4,
    parameter int PGM_CYC = 8,
    parameter int ERS_CYC = 40
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_pgm,
    input  logic                         start_ers,
    input  logic                         sus_req,
    input  logic                         rsm_req,
    input  logic                         rd_strobe,
    input  logic [ARR_AW-1:0]            addr_idx,
    input  logic [7:0]                   wdata,
    input  logic [SECTORS-1:0]           prot,
    output logic                         busy,
    output logic [7:0]                   status,
    output logic                         mem_pgm_en,
    output logic [ARR_AW-1:0]            mem_pgm_idx,
    output logic [7:0]                   mem_pgm_data,
    output logic                         mem_ers_en,
    output logic [$clog2(SECTORS)-1:0]   mem_ers_sec
);
    localparam int SEC_W = $clog2(SECTORS);
    localparam int PC_W  = $clog2(PGM_CYC + 1);
    localparam int EC_W  = $clog2(ERS_CYC + 1);

    logic              pg_busy;
    logic [PC_W-1:0]   pg_cnt;
    logic [ARR_AW-1:0] pg_idx;
    logic [7:0]        pg_data;
    logic              er_pend, er_susp;
    logic [EC_W-1:0]   er_cnt;
    logic [SEC_W-1:0]  er_sec;
    logic              tog;
    logic [SEC_W-1:0]  tgt_sec, pg_sec;
    logic              pgm_ok, ers_ok, er_run;

    assign tgt_sec = addr_idx[ARR_AW-1 -: SEC_W];
    assign pg_sec  = pg_idx[ARR_AW-1 -: SEC_W];
    assign er_run  = er_pend && !er_susp;
    assign pgm_ok  = start_pgm && !prot[tgt_sec] && !(er_pend && tgt_sec == er_sec);
    assign ers_ok  = start_ers && !prot[tgt_sec] && !er_pend;
    assign busy    = pg_busy || er_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_busy <= 1'b0;
            pg_cnt  <= '0;
            pg_idx  <= '0;
            pg_data <= '0;
        end else if (pgm_ok) begin
            pg_busy <= 1'b1;
            pg_cnt  <= PC_W'(PGM_CYC - 1);
            pg_idx  <= addr_idx;
            pg_data <= wdata;
        end else if (pg_busy) begin
            if (pg_cnt == '0) pg_busy <= 1'b0;
            else              pg_cnt  <= pg_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            er_pend <= 1'b0;
            er_susp <= 1'b0;
            er_cnt  <= '0;
            er_sec  <= '0;
        end else if (ers_ok) begin
            er_pend <= 1'b1;
            er_susp <= 1'b0;
            er_cnt  <= EC_W'(ERS_CYC - 1);
            er_sec  <= tgt_sec;
        end else if (er_run) begin
            if (sus_req)           er_susp <= 1'b1;
            else if (er_cnt == '0) er_pend <= 1'b0;
            else                   er_cnt  <= er_cnt - 1'b1;
        end else if (er_pend && rsm_req && !pg_busy) begin
            er_susp <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 tog <= 1'b0;
        else if (rd_strobe && busy) tog <= ~tog;
    end

    always_comb begin
        mem_pgm_en   = pg_busy && (pg_cnt == '0);
        mem_pgm_idx  = pg_idx;
        mem_pgm_data = pg_data;
        mem_ers_en   = er_run && !sus_req && (er_cnt == '0);
        mem_ers_sec  = er_sec;
        status       = {pg_busy ? ~pg_data[7] : 1'b0, tog, 6'b0};
    end

    // R5: no program launch into a protected sector
    p_prot_pgm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg_busy) |-> !prot[pg_sec]);

    // R7: a program during suspend never targets the suspended sector
    p_susp_sector_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (er_pend && er_susp && pg_busy) |-> (pg_sec != er_sec));

    // R8: a program and a running erase never overlap
    p_single_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pg_busy && er_run));
endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl #(
    parameter int ADDR_W  = 11,
    parameter int ARR_AW  = 6,
    parameter int SECTORS = 4,
    parameter int PGM_CYC = 8,
    parameter int ERS_CYC = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               we_n,
    input  logic               oe_n,
    input  logic               pwr_low,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [7:0]         wdata,
    input  logic [SECTORS-1:0] prot,
    output logic [7:0]         rdata,
    output logic               busy
);
    localparam int SEC_W = $clog2(SECTORS);

    logic              wr, rd;
    logic              start_pgm, start_ers, sus_req, rsm_req;
    logic [7:0]        status, arr_data;
    logic              m_pgm_en, m_ers_en;
    logic [ARR_AW-1:0] m_pgm_idx;
    logic [7:0]        m_pgm_data;
    logic [SEC_W-1:0]  m_ers_sec;

    assign wr = !cs_n && !we_n && !pwr_low;
    assign rd = !cs_n && !oe_n;

    nor_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr(wr), .busy(busy),
        .addr(addr), .data(wdata),
        .start_pgm(start_pgm), .start_ers(start_ers),
        .sus_req(sus_req), .rsm_req(rsm_req)
    );

    nor_op_engine #(
        .ARR_AW(ARR_AW), .SECTORS(SECTORS),
        .PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC)
    ) u_eng (
        .clk(clk), .rst_n(rst_n),
        .start_pgm(start_pgm), .start_ers(start_ers),
        .sus_req(sus_req), .rsm_req(rsm_req), .rd_strobe(rd),
        .addr_idx(addr[ARR_AW-1:0]), .wdata(wdata), .prot(prot),
        .busy(busy), .status(status),
        .mem_pgm_en(m_pgm_en), .mem_pgm_idx(m_pgm_idx), .mem_pgm_data(m_pgm_data),
        .mem_ers_en(m_ers_en), .mem_ers_sec(m_ers_sec)
    );

    nor_cell_array #(.ARR_AW(ARR_AW), .SEC_W(SEC_W)) u_arr (
        .clk(clk), .rst_n(rst_n),
        .pgm_en(m_pgm_en), .pgm_idx(m_pgm_idx), .pgm_data(m_pgm_data),
        .ers_en(m_ers_en), .ers_sec(m_ers_sec),
        .rd_idx(addr[ARR_AW-1:0]), .rd_data(arr_data)
    );

    assign rdata = busy ? status : arr_data;

    // R6: with the supply flag raised, no operation can begin
    p_lowsupply_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_low |=> !$rose(busy));
endmodule

// File: tb/nor_cmd_ctrl_test.sv
module nor_cmd_ctrl_test;
    localparam int PGM_CYC = 8;
    localparam int ERS_CYC = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, pwr_low = 1'b0;
    logic [10:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [3:0] prot = '0;
    logic [7:0] rdata;
    logic       busy;

    int checks = 0;
    int errors = 0;

    nor_cmd_ctrl #(.PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .pwr_low(pwr_low), .addr(addr), .wdata(wdata), .prot(prot),
        .rdata(rdata), .busy(busy)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic bus_rd(input logic [10:0] a, output logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; oe_n = 1'b0; addr = a;
        #1 d = rdata;
        cs_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic unlock();
        bus_wr(11'h555, 8'hAA);
        bus_wr(11'h2AA, 8'h55);
    endtask

    task automatic pgm(input logic [10:0] a, input logic [7:0] d);
        unlock();
        bus_wr(11'h555, 8'hA0);
        bus_wr(a, d);
    endtask

    task automatic ers(input logic [10:0] a);
        unlock();
        bus_wr(11'h555, 8'h80);
        unlock();
        bus_wr(a, 8'h30);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic expect_rd(input logic [10:0] a, input logic [7:0] e, input string tag);
        logic [7:0] v;
        bus_rd(a, v);
        chk(v == e, tag, v, e);
    endtask

    task automatic t_reset();
        #1 chk(busy == 1'b0, "R4 busy after reset", busy, 0);
        expect_rd(11'h000, 8'hFF, "R4 erased after reset");
    endtask

    task automatic t_program();
        int n;
        pgm(11'h005, 8'hA5);
        wait_idle(n);
        chk(n == PGM_CYC, "R1 program busy length", n, PGM_CYC);
        expect_rd(11'h005, 8'hA5, "R1 program data");
        pgm(11'h005, 8'h0F);
        wait_idle(n);
        expect_rd(11'h005, 8'h05, "R11 program ANDs bits");
    endtask

    task automatic t_status();
        int n;
        logic [7:0] s1, s2;
        pgm(11'h006, 8'h3C);
        cs_n = 1'b0; oe_n = 1'b0; addr = 11'h006;
        #1 s1 = rdata;
        @(negedge clk);
        #1 s2 = rdata;
        cs_n = 1'b1; oe_n = 1'b1;
        chk(s1[7] == 1'b1 && s1[5:0] == 6'd0, "R10 program status bits", s1, 8'h80);
        chk(s1[6] != s2[6], "R10 toggle bit", s2[6], !s1[6]);
        wait_idle(n);
        expect_rd(11'h006, 8'h3C, "R10 data after status");
    endtask

    task automatic t_bypass();
        int n;
        unlock();
        bus_wr(11'h555, 8'h20);
        bus_wr(11'h123, 8'hA0);
        bus_wr(11'h007, 8'h12);
        wait_idle(n);
        chk(n == PGM_CYC, "R2 bypass program busy", n, PGM_CYC);
        expect_rd(11'h007, 8'h12, "R2 bypass program data");
        bus_wr(11'h000, 8'h90);
        bus_wr(11'h000, 8'h00);
        bus_wr(11'h000, 8'hA0);
        bus_wr(11'h008, 8'h00);
        #1 chk(busy == 1'b0, "R2 no program after leaving bypass", busy, 0);
        expect_rd(11'h008, 8'hFF, "R2 data unchanged after exit");
    endtask

    task automatic t_broken();
        int n;
        bus_wr(11'h555, 8'hAA);
        bus_wr(11'h2AA, 8'h12);
        bus_wr(11'h555, 8'hA0);
        bus_wr(11'h009, 8'h00);
        #1 chk(busy == 1'b0, "R3 broken sequence busy", busy, 0);
        expect_rd(11'h009, 8'hFF, "R3 broken sequence data");
        pgm(11'h00A, 8'h77);
        wait_idle(n);
        expect_rd(11'h00A, 8'h77, "R3 sequence after break");
    endtask

    task automatic t_busy_ignore();
        int n;
        pgm(11'h00B, 8'hF0);
        unlock();
        bus_wr(11'h555, 8'hA0);
        wait_idle(n);
        bus_wr(11'h00C, 8'h00);
        #1 chk(busy == 1'b0, "R8 writes during busy ignored", busy, 0);
        expect_rd(11'h00C, 8'hFF, "R8 ignored target untouched");
        expect_rd(11'h00B, 8'hF0, "R8 running program intact");
    endtask

    task automatic t_erase();
        int n;
        pgm(11'h012, 8'h44);
        wait_idle(n);
        ers(11'h000);
        wait_idle(n);
        chk(n == ERS_CYC, "R9 erase busy length", n, ERS_CYC);
        expect_rd(11'h005, 8'hFF, "R9 erased byte");
        expect_rd(11'h00B, 8'hFF, "R9 erased byte 2");
        expect_rd(11'h012, 8'h44, "R9 other sector kept");
    endtask

    task automatic t_protect();
        int n;
        prot = 4'b0010;
        ers(11'h010);
        #1 chk(busy == 1'b0, "R5 protected erase busy", busy, 0);
        expect_rd(11'h012, 8'h44, "R5 protected erase data");
        pgm(11'h013, 8'h00);
        #1 chk(busy == 1'b0, "R5 protected program busy", busy, 0);
        expect_rd(11'h013, 8'hFF, "R5 protected program data");
        prot = 4'b0000;
        pgm(11'h013, 8'h00);
        wait_idle(n);
        expect_rd(11'h013, 8'h00, "R5 unprotected program");
    endtask

    task automatic t_lowsupply();
        pwr_low = 1'b1;
        pgm(11'h030, 8'h00);
        #1 chk(busy == 1'b0, "R6 low supply busy", busy, 0);
        pwr_low = 1'b0;
        expect_rd(11'h030, 8'hFF, "R6 low supply data");
    endtask

    task automatic t_suspend();
        int n;
        pgm(11'h031, 8'h5A);
        wait_idle(n);
        ers(11'h030);
        repeat (5) @(negedge clk);
        bus_wr(11'h000, 8'hB0);
        #1 chk(busy == 1'b0, "R7 suspend clears busy", busy, 0);
        expect_rd(11'h031, 8'h5A, "R7 read during suspend");
        pgm(11'h002, 8'h33);
        wait_idle(n);
        chk(n == PGM_CYC, "R7 program during suspend", n, PGM_CYC);
        expect_rd(11'h002, 8'h33, "R7 program data during suspend");
        pgm(11'h032, 8'h00);
        #1 chk(busy == 1'b0, "R7 suspended sector rejected", busy, 0);
        bus_wr(11'h000, 8'h30);
        #1 chk(busy == 1'b1, "R7 resume sets busy", busy, 1);
        wait_idle(n);
        expect_rd(11'h031, 8'hFF, "R7 erase completed");
        expect_rd(11'h002, 8'h33, "R7 other sector kept");
    endtask

    task automatic t_hwreset();
        unlock();
        bus_wr(11'h555, 8'h20);
        bus_wr(11'h000, 8'hA0);
        bus_wr(11'h003, 8'h00);
        #1 chk(busy == 1'b1, "R4 program running before reset", busy, 1);
        rst_n = 1'b0;
        #1 chk(busy == 1'b0, "R4 reset aborts", busy, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        bus_wr(11'h000, 8'hA0);
        bus_wr(11'h004, 8'h00);
        #1 chk(busy == 1'b0, "R4 bypass left by reset", busy, 0);
        expect_rd(11'h004, 8'hFF, "R4 array after reset");
        expect_rd(11'h002, 8'hFF, "R4 array reinitialised");
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_status();
        t_bypass();
        t_broken();
        t_busy_ignore();
        t_erase();
        t_protect();
        t_lowsupply();
        t_suspend();
        t_hwreset();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule